// File: doc/BRIEF.md
# Cache-to-Memory Request Handshake Responder

This block sits on the memory-controller side of the request link from a last-level cache. It takes single-cycle request pulses of three kinds (normal read, dummy read and write), keeps a count of the request-queue entries it holds, and raises a full flag when that count reaches the configured depth. A dequeue strobe stands in for the memory side that drains the queue.

Every accepted write starts a handshake sequence. First comes a one-cycle write acknowledge after a programmable delay. Then write-data-valid stays low for a programmable gap. Then it is held high for a fixed window of eight cycles, which tells the cache to drive write data. Writes that arrive while a sequence is running wait in a small pending counter and are served one sequence at a time.

A dummy read taken while the queue has room is answered with a one-cycle dummy acknowledge. Requester misbehaviour sets a sticky protocol-error flag. That covers two requests in one cycle and any read while the queue is full. Writes are still accepted while the queue is full.

Top module: `cache_req_responder`

## Requirements
- R1: If two or more of `rd_req`, `dummy_rd_req` and `wr_req` are high in the same cycle, `proto_err` is high from the next cycle on. None of those requests is counted, acknowledged or queued.
- R2: A write request accepted in cycle k while no sequence is running and none is pending gives exactly one cycle of `wr_ack`, in cycle k+D. D is `ack_cfg` clamped to the range 1..50.
- R3: After the `wr_ack` cycle, `wr_data_vld` stays low for exactly G cycles and then rises. G is `gap_cfg` clamped to the range 5..7.
- R4: Each time `wr_data_vld` rises, it stays high for exactly 8 consecutive cycles and then falls.
- R5: Writes that arrive while a sequence runs are kept pending and served in order. If L is the last valid cycle of the running sequence, the next `wr_ack` comes in cycle L+D.
- R6: `q_count` rises by one for each request accepted while the queue is not full. It falls by one on `deq` when the count is non-zero, and `deq` at zero has no effect. `q_full` is high exactly when `q_count` equals DEPTH (default 8).
- R7: A normal read in a cycle where `q_full` is high sets `proto_err` from the next cycle and is not queued.
- R8: A dummy read while not full gives `dummy_ack` high for one cycle, in the following cycle. A dummy read while full sets `proto_err` and gives no `dummy_ack`.
- R9: A write while `q_full` is high gets its full ack and valid sequence. It does not set `proto_err` and does not change `q_count`.
- R10: A synchronous active-high `rst` clears `q_count`, `q_full`, `proto_err`, `dummy_ack`, the pending writes and any running sequence.
- R11: Once set, `proto_err` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Normal read request pulse |
| dummy_rd_req | input | 1 | Dummy read request pulse |
| wr_req | input | 1 | Write request pulse |
| deq | input | 1 | Removes one queue entry when non-empty |
| ack_cfg | input | 6 | Write acknowledge delay, clamped to 1..50 |
| gap_cfg | input | 3 | Acknowledge to data-valid gap, clamped to 5..7 |
| q_count | output | 4 | Queue occupancy |
| q_full | output | 1 | Occupancy equals DEPTH |
| dummy_ack | output | 1 | One-cycle answer to an accepted dummy read |
| wr_ack | output | 1 | One-cycle write acknowledge |
| wr_data_vld | output | 1 | Eight-cycle write data window |
| proto_err | output | 1 | Sticky protocol-violation flag |

## Verification
Two functions can fall in the same cycle and need care. The first pair is a new write request and the last valid cycle of a running sequence: the new write must start the next sequence at once, with no idle cycle and no lost request. The bench provokes this by sending writes back to back and then sending one more write timed to land during a valid window. The second pair is a write arriving while the queue is full, alongside reads and dummy reads arriving at that same full point. The bench fills the queue and then sends each kind of request. A behavioural model, built from per-cycle event tables, predicts every output, and each cycle is judged against it.

// File: rtl/crr_pkg.sv
package crr_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_WAIT  = 2'd1,
      SQ_GAP   = 2'd2,
      SQ_VALID = 2'd3
   } seq_state_e;

   function automatic int clamp_int(input int v, input int lo, input int hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/crr_req_check.sv
module crr_req_check (
   input  logic rd,
   input  logic dummy,
   input  logic wr,
   input  logic full,
   output logic enq,
   output logic wr_acc,
   output logic dummy_ok,
   output logic viol
);
   logic conflict;
   logic any_rd;

   always_comb begin
      conflict = (rd & dummy) | (rd & wr) | (dummy & wr);
      any_rd   = rd | dummy;
      viol     = conflict | (full & any_rd);
      wr_acc   = wr & ~conflict;
      dummy_ok = dummy & ~conflict & ~full;
      enq      = ~conflict & ~full & (any_rd | wr);
   end
endmodule

// File: rtl/crr_occupancy.sv
module crr_occupancy #(
   parameter int DEPTH = 8,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          enq,
   input  logic          deq,
   output logic [CW-1:0] count,
   output logic          full
);
   logic [CW-1:0] count_q;
   logic          dec;

   assign dec   = deq && (count_q != '0);
   assign full  = (count_q == CW'(DEPTH));
   assign count = count_q;

   always_ff @(posedge clk) begin
      if (rst)               count_q <= '0;
      else if (enq && !dec)  count_q <= count_q + 1'b1;
      else if (!enq && dec)  count_q <= count_q - 1'b1;
   end
endmodule

// File: rtl/crr_wr_seq.sv
module crr_wr_seq
   import crr_pkg::*;
#(
   parameter int ACK_MIN = 1,
   parameter int ACK_MAX = 50,
   parameter int GAP_MIN = 5,
   parameter int GAP_MAX = 7,
   parameter int VLD_LEN = 8,
   parameter int PEND_W  = 4,
   localparam int ACK_W  = $clog2(ACK_MAX + 1),
   localparam int GAP_W  = $clog2(GAP_MAX + 1),
   localparam int SEQ_MX = max3(ACK_MAX, GAP_MAX, VLD_LEN),
   localparam int CNT_W  = $clog2(SEQ_MX + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_acc,
   input  logic [ACK_W-1:0] ack_cfg,
   input  logic [GAP_W-1:0] gap_cfg,
   output logic             wr_ack,
   output logic             wr_data_vld
);
   seq_state_e        st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [PEND_W-1:0] pend_q;
   logic [CNT_W-1:0]  ack_ld;
   logic [CNT_W-1:0]  gap_ld;
   logic              last_vld;
   logic              start;
   logic              pend_full;

   assign ack_ld    = CNT_W'(clamp_int(int'(ack_cfg), ACK_MIN, ACK_MAX) - 1);
   assign gap_ld    = CNT_W'(clamp_int(int'(gap_cfg), GAP_MIN, GAP_MAX) - 1);
   assign last_vld  = (st_q == SQ_VALID) && (cnt_q == '0);
   assign start     = (wr_acc || (pend_q != '0)) && ((st_q == SQ_IDLE) || last_vld);
   assign pend_full = &pend_q;

   assign wr_ack      = (st_q == SQ_WAIT) && (cnt_q == '0);
   assign wr_data_vld = (st_q == SQ_VALID);

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= '0;
      end else if (wr_acc && !start && !pend_full) begin
         pend_q <= pend_q + 1'b1;
      end else if (!wr_acc && start) begin
         pend_q <= pend_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= SQ_IDLE;
         cnt_q <= '0;
      end else begin
         case (st_q)
            SQ_IDLE: begin
               if (start) begin
                  st_q  <= SQ_WAIT;
                  cnt_q <= ack_ld;
               end
            end
            SQ_WAIT: begin
               if (cnt_q == '0) begin
                  st_q  <= SQ_GAP;
                  cnt_q <= gap_ld;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            SQ_GAP: begin
               if (cnt_q == '0) begin
                  st_q  <= SQ_VALID;
                  cnt_q <= CNT_W'(VLD_LEN - 1);
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: begin
               if (cnt_q != '0) begin
                  cnt_q <= cnt_q - 1'b1;
               end else if (start) begin
                  st_q  <= SQ_WAIT;
                  cnt_q <= ack_ld;
               end else begin
                  st_q  <= SQ_IDLE;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/cache_req_responder.sv
module cache_req_responder #(
   parameter int DEPTH   = 8,
   parameter int ACK_MIN = 1,
   parameter int ACK_MAX = 50,
   parameter int GAP_MIN = 5,
   parameter int GAP_MAX = 7,
   parameter int VLD_LEN = 8,
   parameter int PEND_W  = 4,
   localparam int ACK_W  = $clog2(ACK_MAX + 1),
   localparam int GAP_W  = $clog2(GAP_MAX + 1),
   localparam int QC_W   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rd_req,
   input  logic             dummy_rd_req,
   input  logic             wr_req,
   input  logic             deq,
   input  logic [ACK_W-1:0] ack_cfg,
   input  logic [GAP_W-1:0] gap_cfg,
   output logic [QC_W-1:0]  q_count,
   output logic             q_full,
   output logic             dummy_ack,
   output logic             wr_ack,
   output logic             wr_data_vld,
   output logic             proto_err
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("cache_req_responder: DEPTH must be at least 2");
   end
   if (ACK_MIN < 1 || ACK_MAX < ACK_MIN) begin : g_bad_ack
      $error("cache_req_responder: acknowledge delay range is invalid");
   end
   if (GAP_MIN < 1 || GAP_MAX < GAP_MIN) begin : g_bad_gap
      $error("cache_req_responder: gap range is invalid");
   end
   if (VLD_LEN < 1 || PEND_W < 1) begin : g_bad_len
      $error("cache_req_responder: VLD_LEN and PEND_W must be positive");
   end

   logic enq, wr_acc, dummy_ok, viol;
   logic err_q, dack_q;

   crr_req_check u_check (
      .rd       (rd_req),
      .dummy    (dummy_rd_req),
      .wr       (wr_req),
      .full     (q_full),
      .enq      (enq),
      .wr_acc   (wr_acc),
      .dummy_ok (dummy_ok),
      .viol     (viol)
   );

   crr_occupancy #(.DEPTH(DEPTH)) u_occ (
      .clk   (clk),
      .rst   (rst),
      .enq   (enq),
      .deq   (deq),
      .count (q_count),
      .full  (q_full)
   );

   crr_wr_seq #(
      .ACK_MIN (ACK_MIN),
      .ACK_MAX (ACK_MAX),
      .GAP_MIN (GAP_MIN),
      .GAP_MAX (GAP_MAX),
      .VLD_LEN (VLD_LEN),
      .PEND_W  (PEND_W)
   ) u_seq (
      .clk         (clk),
      .rst         (rst),
      .wr_acc      (wr_acc),
      .ack_cfg     (ack_cfg),
      .gap_cfg     (gap_cfg),
      .wr_ack      (wr_ack),
      .wr_data_vld (wr_data_vld)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         err_q  <= 1'b0;
         dack_q <= 1'b0;
      end else begin
         err_q  <= err_q | viol;
         dack_q <= dummy_ok;
      end
   end

   assign proto_err = err_q;
   assign dummy_ack = dack_q;
endmodule

// File: rtl/crr_checker.sv
module crr_checker #(
   parameter int DEPTH   = 8,
   parameter int GAP_MIN = 5,
   parameter int GAP_MAX = 7,
   parameter int VLD_LEN = 8,
   localparam int QC_W   = $clog2(DEPTH + 1)
) (
   input logic            clk,
   input logic            rst,
   input logic            rd_req,
   input logic            dummy_rd_req,
   input logic            wr_req,
   input logic            deq,
   input logic [QC_W-1:0] q_count,
   input logic            q_full,
   input logic            dummy_ack,
   input logic            wr_ack,
   input logic            wr_data_vld,
   input logic            proto_err
);
   logic [7:0] gap_cnt;
   logic [7:0] run_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         gap_cnt <= 8'hFF;
         run_cnt <= '0;
      end else begin
         if (wr_ack)                         gap_cnt <= '0;
         else if (!wr_data_vld && gap_cnt != 8'hFF) gap_cnt <= gap_cnt + 1'b1;
         if (wr_data_vld) run_cnt <= run_cnt + 1'b1;
         else             run_cnt <= '0;
      end
   end

   a_r1_conflict_err: assert property (@(posedge clk) disable iff (rst)
      ((rd_req && wr_req) || (dummy_rd_req && wr_req) || (rd_req && dummy_rd_req)) |=> proto_err);

   a_r2_ack_single: assert property (@(posedge clk) disable iff (rst)
      wr_ack |=> !wr_ack);

   a_r3_gap_legal: assert property (@(posedge clk) disable iff (rst)
      $rose(wr_data_vld) |-> (gap_cnt >= 8'(GAP_MIN) && gap_cnt <= 8'(GAP_MAX)));

   a_r4_vld_bound: assert property (@(posedge clk) disable iff (rst)
      wr_data_vld |-> (run_cnt < 8'(VLD_LEN)));

   a_r4_vld_length: assert property (@(posedge clk) disable iff (rst)
      $fell(wr_data_vld) |-> (run_cnt == 8'(VLD_LEN)));

   a_r6_full_holds: assert property (@(posedge clk) disable iff (rst)
      (q_full && !deq) |=> (q_count == $past(q_count)));

   a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
      q_count <= QC_W'(DEPTH));

   a_r7_rd_full_err: assert property (@(posedge clk) disable iff (rst)
      (rd_req && q_full) |=> proto_err);

   a_r8_dummy_full_noack: assert property (@(posedge clk) disable iff (rst)
      (dummy_rd_req && q_full) |=> (!dummy_ack && proto_err));

   a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
      proto_err |=> proto_err);
endmodule

bind cache_req_responder crr_checker #(
   .DEPTH   (DEPTH),
   .GAP_MIN (GAP_MIN),
   .GAP_MAX (GAP_MAX),
   .VLD_LEN (VLD_LEN)
) u_chk (.*);

// File: tb/cache_req_responder_tb_top.sv
module cache_req_responder_tb_top;
   localparam int DEPTH = 8;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       rd_req = 1'b0, dummy_rd_req = 1'b0, wr_req = 1'b0, deq = 1'b0;
   logic [5:0] ack_cfg = 6'd3;
   logic [2:0] gap_cfg = 3'd5;
   logic [3:0] q_count;
   logic       q_full, dummy_ack, wr_ack, wr_data_vld, proto_err;

   int  checks = 0, fails = 0, n = 0, wd = 0;
   int  m_cnt = 0, last_end = -100;
   bit  m_err = 0, m_dack = 0, done = 0;
   bit  exp_ack[int];
   bit  exp_vld[int];

   always #5 clk = ~clk;

   cache_req_responder dut_i (
      .clk(clk), .rst(rst), .rd_req(rd_req), .dummy_rd_req(dummy_rd_req),
      .wr_req(wr_req), .deq(deq), .ack_cfg(ack_cfg), .gap_cfg(gap_cfg),
      .q_count(q_count), .q_full(q_full), .dummy_ack(dummy_ack),
      .wr_ack(wr_ack), .wr_data_vld(wr_data_vld), .proto_err(proto_err)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, n, act, exp);
      end
   endtask

   function automatic int clampv(input int v, input int lo, input int hi);
      return (v < lo) ? lo : ((v > hi) ? hi : v);
   endfunction

   task automatic schedule(input int k);
      int e, d, g;
      d = clampv(int'(ack_cfg), 1, 50);
      g = clampv(int'(gap_cfg), 5, 7);
      e = (k > last_end) ? k : last_end;
      exp_ack[e + d] = 1'b1;
      for (int i = 1; i <= 8; i++) exp_vld[e + d + g + i] = 1'b1;
      last_end = e + d + g + 8;
   endtask

   // Reference model update at the edge, then compare just after it.
   task automatic tick(input string tag);
      int  nreq;
      bit  full, enq, wacc;
      @(posedge clk);
      n++;
      if (rst) begin
         m_cnt = 0; m_err = 0; m_dack = 0; last_end = -100;
         exp_ack.delete(); exp_vld.delete();
      end else begin
         nreq = int'(rd_req) + int'(dummy_rd_req) + int'(wr_req);
         full = (m_cnt == DEPTH);
         enq = 0; wacc = 0; m_dack = 0;
         if (nreq > 1) begin
            m_err = 1;
         end else begin
            if (rd_req) begin if (full) m_err = 1; else enq = 1; end
            if (dummy_rd_req) begin
               if (full) m_err = 1; else begin enq = 1; m_dack = 1; end
            end
            if (wr_req) begin wacc = 1; if (!full) enq = 1; end
         end
         if (wacc) schedule(n);
         m_cnt = m_cnt + int'(enq) - ((deq && m_cnt > 0) ? 1 : 0);
      end
      #1;
      chk(wr_ack == exp_ack.exists(n + 1), {tag, " R2 wr_ack"}, int'(wr_ack), int'(exp_ack.exists(n + 1)));
      chk(wr_data_vld == exp_vld.exists(n + 1), {tag, " R3/R4 wr_data_vld"}, int'(wr_data_vld), int'(exp_vld.exists(n + 1)));
      chk(int'(q_count) == m_cnt, {tag, " R6 q_count"}, int'(q_count), m_cnt);
      chk(q_full == (m_cnt == DEPTH), {tag, " R6 q_full"}, int'(q_full), int'(m_cnt == DEPTH));
      chk(proto_err == m_err, {tag, " R11 proto_err"}, int'(proto_err), int'(m_err));
      chk(dummy_ack == m_dack, {tag, " R8 dummy_ack"}, int'(dummy_ack), int'(m_dack));
   endtask

   task automatic idle(input int cnt, input string tag);
      rd_req = 0; dummy_rd_req = 0; wr_req = 0; deq = 0;
      for (int i = 0; i < cnt; i++) tick(tag);
   endtask

   task automatic pulse(input bit r, input bit d, input bit w, input string tag);
      rd_req = r; dummy_rd_req = d; wr_req = w;
      tick(tag);
      rd_req = 0; dummy_rd_req = 0; wr_req = 0;
   endtask

   task automatic do_reset();
      rst = 1; tick("R10 reset"); tick("R10 reset"); rst = 0;
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 100000 && !done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      do_reset();
      chk(q_count == 0 && !q_full && !proto_err && !wr_ack && !wr_data_vld && !dummy_ack,
          "R10 reset state", int'(q_count), 0);

      // R2 R3 R4 basic write
      ack_cfg = 6'd3; gap_cfg = 3'd5;
      pulse(0, 0, 1, "R2 single write");
      idle(25, "R2 single write");

      // R2 R3 clamps at the low end
      ack_cfg = 6'd0; gap_cfg = 3'd0;
      pulse(0, 0, 1, "R3 low clamp");
      idle(20, "R3 low clamp");

      // R2 R3 clamps at the high end
      ack_cfg = 6'd63; gap_cfg = 3'd7;
      pulse(0, 0, 1, "R2 high clamp");
      idle(70, "R2 high clamp");

      // R5 back-to-back writes and a write landing in a valid window
      ack_cfg = 6'd2; gap_cfg = 3'd6;
      pulse(0, 0, 1, "R5 pending");
      pulse(0, 0, 1, "R5 pending");
      idle(1, "R5 pending");
      pulse(0, 0, 1, "R5 pending");
      idle(12, "R5 pending");
      pulse(0, 0, 1, "R5 overlap valid");
      idle(70, "R5 pending");

      // R6 drain, then dequeue at empty is ignored
      deq = 1;
      for (int i = 0; i < 8; i++) tick("R6 dequeue");
      deq = 0;

      // R1 conflicting requests, R11 sticky
      pulse(1, 0, 1, "R1 rd+wr");
      idle(20, "R1 nothing accepted");
      pulse(0, 1, 1, "R1 dummy+wr");
      idle(5, "R11 sticky");
      do_reset();

      // fill queue with reads and dummy reads
      ack_cfg = 6'd4; gap_cfg = 3'd5;
      for (int i = 0; i < 4; i++) pulse(1, 0, 0, "R6 fill");
      for (int i = 0; i < 4; i++) pulse(0, 1, 0, "R8 dummy not full");
      idle(2, "R6 full");

      // R9 write while full: sequence, no error
      pulse(0, 0, 1, "R9 write while full");
      idle(25, "R9 write while full");

      // R8 dummy read while full
      pulse(0, 1, 0, "R8 dummy while full");
      idle(3, "R8 dummy while full");
      do_reset();

      // R7 read while full
      for (int i = 0; i < 8; i++) pulse(1, 0, 0, "R7 fill");
      pulse(1, 0, 0, "R7 read while full");
      idle(3, "R7 read while full");

      // R10 reset in the middle of a sequence cancels it
      do_reset();
      ack_cfg = 6'd6;
      pulse(0, 0, 1, "R10 mid-sequence");
      pulse(0, 0, 1, "R10 mid-sequence");
      idle(2, "R10 mid-sequence");
      do_reset();
      idle(40, "R10 cancelled");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule